// File: doc/BRIEF.md
# Serial Synthesizer Programming Controller

This block sits on the host side of a three-wire serial link to a frequency-synthesizer device. The link has a serial clock, a serial data line and a latch strobe. The block takes 24-bit words from a valid/ready request port and shifts each one out most significant bit first. It changes data only while the serial clock is low, so the device can sample on the rising edge. After the last bit it raises the latch strobe for one serial-clock period, and the device then commits the word into the latch that the word's two lowest bits select.

When reset is released the controller programs the device by itself with three fixed words. These are the initialization latch word, then the reference-counter word, then the feedback-counter word, all taken from parameters. Host requests are held off until this sequence has finished. The block also drives the device's power-down control from a host input, and passes the device's lock indication through a synchronizer into a status bit.

The serial clock half-period is derived from the system clock frequency and the maximum allowed serial clock rate. The serial clock therefore never runs faster than that limit.

Top module: `synth_prog_ctrl`

## Requirements
- R1: While reset is active, `sclk`, `sdata`, `le`, `req_ready`, `init_done` and `dev_ce` are all low.
- R2: Every frame carries exactly 24 rising `sclk` edges while `le` is low, sent most significant bit first. The word arrives bit for bit, with its two lowest (latch-select) bits unchanged.
- R3: `sdata` changes only while `sclk` is low. Each high phase of `sclk`, and each low phase between bits, lasts HALF_DIV system cycles, where HALF_DIV = ceil(SYS_CLK_HZ / (2*SCLK_MAX_HZ)) (4 at defaults). This keeps `sclk` at or below SCLK_MAX_HZ.
- R4: `le` rises only after the 24th bit, with `sclk` low. It stays high for exactly 2*HALF_DIV cycles (one serial period) with `sclk` low. At least 2*HALF_DIV cycles then pass from the fall of `le` to the next rising `sclk` edge.
- R5: After reset, three frames go out without any request, in this order: INIT_WORD, RCNT_WORD, NCNT_WORD.
- R6: `init_done` stays low until the third power-up frame has completed, then rises and stays high. `req_ready` is never high while `init_done` is low.
- R7: A word is accepted on a cycle with `req_valid` and `req_ready` both high. Each accepted word is sent exactly once, in acceptance order, and `req_ready` is low while a frame is in progress.
- R8: `dev_ce` equals `ce_req` delayed by one system clock.
- R9: `lock_status` follows `lock_raw` through two flip-flops. A change on `lock_raw` is not visible after one rising clock edge and is visible after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a word |
| req_word | input | 24 | Word to program, latch-select in bits 1:0 |
| req_ready | output | 1 | Controller can accept a word this cycle |
| ce_req | input | 1 | Host request to power the device up |
| lock_raw | input | 1 | Asynchronous lock indication from the device |
| sclk | output | 1 | Serial clock to the device |
| sdata | output | 1 | Serial data to the device |
| le | output | 1 | Latch strobe to the device |
| dev_ce | output | 1 | Registered chip-enable to the device |
| lock_status | output | 1 | Synchronized lock indication |
| init_done | output | 1 | Power-up programming sequence complete |

## Verification
The assertions assume that `req_word` is valid in the cycle a request is accepted, and that `req_valid` may change freely otherwise. They treat `lock_raw` as asynchronous and so place no assertion on it. The stimulus changes every input half a cycle away from the active edge. It holds `req_valid` and the word steady until the handshake completes, then drops `req_valid` one cycle later. This means no request is ever offered in a way that the serial timing properties would have to tolerate mid-frame. The device model in the bench samples `sdata` only on rising `sclk`, so the bench sees exactly the view the real device has.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_LATCH = 2'd2,
      ST_GAP   = 2'd3
   } shift_state_e;

   function automatic int half_div(input int sys_hz, input int max_hz);
      return (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
   endfunction
endpackage

// File: rtl/spc_tick.sv
module spc_tick #(
   parameter int HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(HALF - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spc_shift.sv
module spc_shift
   import spc_pkg::*;
#(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] word,
   input  logic         tick,
   output logic         busy,
   output logic         done,
   output logic         sclk,
   output logic         sdata,
   output logic         le
);
   localparam int BW = $clog2(W);

   shift_state_e  state;
   logic [W-1:0]  shreg;
   logic [BW-1:0] bitcnt;
   logic          ph;

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         shreg  <= '0;
         bitcnt <= '0;
         ph     <= 1'b0;
         sclk   <= 1'b0;
         sdata  <= 1'b0;
         le     <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  shreg  <= word;
                  sdata  <= word[W-1];
                  bitcnt <= '0;
                  sclk   <= 1'b0;
                  state  <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                  end else begin
                     sclk <= 1'b0;
                     if (bitcnt == BW'(W - 1)) begin
                        le    <= 1'b1;
                        ph    <= 1'b0;
                        state <= ST_LATCH;
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                        sdata  <= shreg[W-2];
                        shreg  <= shreg << 1;
                     end
                  end
               end
            end
            ST_LATCH: begin
               if (tick) begin
                  if (ph) begin
                     le    <= 1'b0;
                     ph    <= 1'b0;
                     state <= ST_GAP;
                  end else begin
                     ph <= 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (ph) begin
                     ph    <= 1'b0;
                     sdata <= 1'b0;
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     ph <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R3: data only moves while the serial clock is low
   a_r3_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(sdata));
   // R4: strobe only with the serial clock parked low
   a_r4_le_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      le |-> !sclk);
   // R2: strobe rises only after the last bit of the word
   a_r2_le_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(le) |-> (bitcnt == BW'(W - 1)));
endmodule

// File: rtl/spc_seq.sv
module spc_seq #(
   parameter int          W         = 24,
   parameter logic [W-1:0] INIT_WORD = '0,
   parameter logic [W-1:0] RCNT_WORD = '0,
   parameter logic [W-1:0] NCNT_WORD = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic [W-1:0] req_word,
   output logic         req_ready,
   input  logic         busy,
   input  logic         done,
   output logic         start,
   output logic [W-1:0] word,
   output logic         init_done
);
   logic [1:0]   step;
   logic         init_start;
   logic         host_start;
   logic [W-1:0] boot_word;

   always_comb begin
      unique case (step)
         2'd0:    boot_word = INIT_WORD;
         2'd1:    boot_word = RCNT_WORD;
         default: boot_word = NCNT_WORD;
      endcase
   end

   assign init_start = (step != 2'd3) && !busy;
   assign req_ready  = init_done && !busy;
   assign host_start = req_valid && req_ready;
   assign start      = init_start || host_start;
   assign word       = init_done ? req_word : boot_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step      <= 2'd0;
         init_done <= 1'b0;
      end else begin
         if (init_start) step <= step + 2'd1;
         if (done && step == 2'd3) init_done <= 1'b1;
      end
   end

   // R6: host port gated by completion of the power-up sequence
   a_r6_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> init_done);
   // R6: completion flag is sticky
   a_r6_init_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);
   // R7: no new frame launched while one is in progress
   a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
   import spc_pkg::*;
#(
   parameter int           SYS_CLK_HZ  = 125_000_000,
   parameter int           SCLK_MAX_HZ = 20_000_000,
   parameter int           WORD_W      = 24,
   parameter int           SYNC_STAGES = 2,
   parameter logic [23:0]  INIT_WORD   = 24'h1F80A3,
   parameter logic [23:0]  RCNT_WORD   = 24'h000C80,
   parameter logic [23:0]  NCNT_WORD   = 24'h03E801
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [23:0] req_word,
   output logic        req_ready,
   input  logic        ce_req,
   input  logic        lock_raw,
   output logic        sclk,
   output logic        sdata,
   output logic        le,
   output logic        dev_ce,
   output logic        lock_status,
   output logic        init_done
);
   localparam int HALF_DIV = half_div(SYS_CLK_HZ, SCLK_MAX_HZ);

   if (WORD_W != 24) begin : g_bad_width
      $error("WORD_W must be 24 for this link");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (HALF_DIV < 1 || SYS_CLK_HZ / (2 * HALF_DIV) > SCLK_MAX_HZ) begin : g_bad_div
      $error("serial clock divider out of range");
   end

   logic              tick;
   logic              busy;
   logic              done;
   logic              start;
   logic [WORD_W-1:0] word;

   spc_seq #(
      .W(WORD_W), .INIT_WORD(INIT_WORD), .RCNT_WORD(RCNT_WORD), .NCNT_WORD(NCNT_WORD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
      .req_ready(req_ready), .busy(busy), .done(done), .start(start),
      .word(word), .init_done(init_done)
   );

   spc_tick #(.HALF(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   spc_shift #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .word(word), .tick(tick),
      .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .le(le)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) dev_ce <= 1'b0;
      else        dev_ce <= ce_req;
   end

   logic [SYNC_STAGES-1:0] sync_q;
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) sync_q[i] <= 1'b0;
         else if (i == 0) sync_q[i] <= lock_raw;
         else sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
      end
   end
   assign lock_status = sync_q[SYNC_STAGES-1];

   // R8: chip-enable is the host request one clock later
   a_r8_ce_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (dev_ce == $past(ce_req)));
endmodule

// File: tb/synth_prog_ctrl_tb.sv
module synth_prog_ctrl_tb;
   localparam int HALF = 4;  // ceil(125 MHz / (2 * 20 MHz))
   localparam logic [23:0] W_INIT = 24'h1F80A3;
   localparam logic [23:0] W_RCNT = 24'h000C80;
   localparam logic [23:0] W_NCNT = 24'h03E801;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [23:0] req_word = '0;
   logic req_ready;
   logic ce_req = 1'b0;
   logic lock_raw = 1'b0;
   logic sclk, sdata, le, dev_ce, lock_status, init_done;

   int n_tests = 0;
   int n_fail = 0;
   logic [23:0] exp_q[$];

   always #4 clk = ~clk;

   synth_prog_ctrl #(
      .INIT_WORD(W_INIT), .RCNT_WORD(W_RCNT), .NCNT_WORD(W_NCNT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
      .req_ready(req_ready), .ce_req(ce_req), .lock_raw(lock_raw),
      .sclk(sclk), .sdata(sdata), .le(le), .dev_ce(dev_ce),
      .lock_status(lock_status), .init_done(init_done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: device model plus serial timing checks, sampled at negedge
   logic        p_sclk = 1'b0, p_le = 1'b0, p_sdata = 1'b0;
   int          run_cnt = 0, le_cnt = 0, gap_cnt = 0, nbits = 0, frames = 0;
   logic [23:0] rx = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk && p_sclk && sdata != p_sdata)
            chk(1'b0, "R3 data moved while sclk high", int'(sdata), int'(p_sdata));
         if (sclk != p_sclk) begin
            if (p_sclk)
               chk(run_cnt == HALF, "R3 high phase", run_cnt, HALF);
            else if (nbits > 0 && nbits < 24)
               chk(run_cnt == HALF, "R3 low phase", run_cnt, HALF);
            run_cnt = 1;
         end else begin
            run_cnt++;
         end
         if (sclk && !p_sclk) begin
            if (le) chk(1'b0, "R4 sclk rose with le high", 1, 0);
            if (nbits == 0 && frames > 0)
               chk(gap_cnt >= 2 * HALF, "R4 idle gap", gap_cnt, 2 * HALF);
            rx = {rx[22:0], sdata};
            nbits++;
         end
         if (le && !p_le) begin
            chk(nbits == 24, "R2 bit count", nbits, 24);
            chk(!sclk, "R4 le with sclk low", int'(sclk), 0);
            chk(!req_ready, "R7 ready low in frame", int'(req_ready), 0);
            if (frames < 3) chk(!init_done, "R6 init_done early", int'(init_done), 0);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected frame", int'(rx), 0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               chk(rx == e, (frames < 3) ? "R5 power-up word" : "R2 word", int'(rx), int'(e));
            end
            frames++;
            nbits = 0;
            le_cnt = 0;
         end
         if (le) le_cnt++;
         if (!le && p_le) begin
            chk(le_cnt == 2 * HALF, "R4 le width", le_cnt, 2 * HALF);
            gap_cnt = 0;
         end
         gap_cnt++;
      end
      p_sclk = sclk;
      p_le = le;
      p_sdata = sdata;
   end

   task automatic send(input logic [23:0] w);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_word = w;
      exp_q.push_back(w);
      @(negedge clk);
      req_valid = 1'b0;
      req_word = ~w;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      #1_500_000;
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!sclk && !sdata && !le, "R1 serial lines idle", int'({sclk, sdata, le}), 0);
      chk(!req_ready && !init_done && !dev_ce, "R1 status low",
          int'({req_ready, init_done, dev_ce}), 0);
      exp_q.push_back(W_INIT);
      exp_q.push_back(W_RCNT);
      exp_q.push_back(W_NCNT);
      rst_n = 1'b1;
      // R6: requests held off while power-up runs
      req_valid = 1'b1;
      req_word = 24'hDEAD00;
      repeat (100) begin
         @(negedge clk);
         if (req_ready && frames < 3) chk(1'b0, "R6 ready during power-up", 1, 0);
      end
      req_valid = 1'b0;
      while (!init_done) @(negedge clk);
      chk(frames == 3, "R6 init_done after third frame", frames, 3);
      chk(exp_q.size() == 0, "R5 three power-up words", exp_q.size(), 0);
      @(negedge clk);
      chk(req_ready, "R6 ready after init", int'(req_ready), 1);
      // R2 / R7: host words, several patterns, back to back
      send(24'hFFFFFF);
      send(24'h000000);
      send(24'hA5A5A6);
      send(24'h5A5A5B);
      send(24'h800001);
      send(24'h123456);
      while (exp_q.size() != 0 || !req_ready) @(negedge clk);
      chk(frames == 9, "R7 each word once", frames, 9);
      chk(init_done, "R6 init_done sticky", int'(init_done), 1);
      // R8: chip-enable delay
      ce_req = 1'b1;
      @(negedge clk);
      chk(dev_ce == 1'b1, "R8 dev_ce rise", int'(dev_ce), 1);
      ce_req = 1'b0;
      @(negedge clk);
      chk(dev_ce == 1'b0, "R8 dev_ce fall", int'(dev_ce), 0);
      // R9: two-flop lock synchronizer
      lock_raw = 1'b1;
      @(negedge clk);
      chk(lock_status == 1'b0, "R9 lock after one edge", int'(lock_status), 0);
      @(negedge clk);
      chk(lock_status == 1'b1, "R9 lock after two edges", int'(lock_status), 1);
      lock_raw = 1'b0;
      @(negedge clk);
      chk(lock_status == 1'b1, "R9 unlock after one edge", int'(lock_status), 1);
      @(negedge clk);
      chk(lock_status == 1'b0, "R9 unlock after two edges", int'(lock_status), 0);
      finish_run();
   end
endmodule